// File: doc/BRIEF.md
# Receive Page DMA Engine with Completion Ring

This block takes a stream of incoming event words and places each event into a host memory page. Software hands over empty pages by pushing descriptors into a free-descriptor FIFO; each descriptor carries a page start byte address and a page size counted in 32-bit words. For every event the engine takes one descriptor and writes the data words to consecutive word addresses of that page through a memory-write master port. The master port always accepts. An event ends with a flagged end-of-event status word. That word is not stored in the page.

When an event is done, the engine writes a two-word entry into a host-visible completion ring, length word first and then status word, and pulses `done`. Software initialises every status word to 0xFFFFFFFF, meaning the entry is not yet loaded. The engine writes 0 when a page has filled but no end-of-event word has arrived yet. It writes the end-of-event word itself once the event has ended. An event that is longer than its page is truncated: the extra words are consumed and dropped, and the final status has the overrun bit set. If the stop-on-error input is high, an overrun event halts the engine after its completion.

The controller has seven states. FETCH waits for a descriptor and pops it (FETCH→MOVE). MOVE stores words. On the end-of-event word it goes MOVE→LEN. On the first word that finds the page full it goes MOVE→PLEN. PLEN writes the partial length (PLEN→PSTAT). PSTAT writes status 0 (PSTAT→DRAIN). DRAIN drops words until the end-of-event word (DRAIN→LEN). LEN writes the final length (LEN→STAT). STAT writes the status, pulses `done`, advances the ring index and returns to FETCH (STAT→FETCH).

Top module: `page_dma_rx`

## Requirements
- R1: After reset `in_ready`, `mw_valid`, `done`, `stopped` and `free_full` are 0, the free FIFO is empty, and the first completion entry after reset goes to ring entry 0.
- R2: The free FIFO holds up to FREE_DEPTH (128) descriptors. `free_full` is 1 exactly when it holds that many. A push while it is full is dropped.
- R3: Descriptors are used in push order. Data word k of an event (k from 0) is written with data unchanged to byte address page_addr + 4·k, as long as k < page size.
- R4: The end-of-event word (`in_eoe`=1) is not written to the page. Completion writes the stored word count to RING_BASE + 8·index, and in the next cycle writes the status to RING_BASE + 8·index + 4.
- R5: The first data word that arrives when the page is already full starts an overrun. That word and every later data word are dropped. The length stays at the page size. An entry with length = page size and status 0 is written first. The final status is the end-of-event word with bit 31 set.
- R6: `done` is high for one cycle per event, in the same cycle as the final status write. The ring index then advances and wraps after RING_DEPTH (8) entries.
- R7: While the free FIFO is empty and the engine has no page, `in_ready` stays 0 and no memory write is made.
- R8: With `stop_en`=1, completing an overrun event sets `stopped`. `stopped` holds until reset, and no further descriptor is taken. With `stop_en`=0, overrun events do not stop the engine.
- R9: `in_ready` is 1 only in MOVE and DRAIN. It is 0 during the ring writes that follow the end-of-event word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_push | input | 1 | Push a free descriptor |
| desc_addr | input | 32 | Page start byte address |
| desc_size | input | 16 | Page size in 32-bit words |
| free_full | output | 1 | Free FIFO holds FREE_DEPTH descriptors |
| stop_en | input | 1 | Halt after an overrun event |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word (data or end-of-event status) |
| in_eoe | input | 1 | Input word is the end-of-event status |
| in_ready | output | 1 | Engine accepts the input word this cycle |
| mw_valid | output | 1 | Memory write strobe |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| done | output | 1 | One-cycle pulse per completed event |
| stopped | output | 1 | Engine halted by the stop-on-error rule |

## Verification
The assertions assume that the memory port accepts every write in the cycle it is offered. They also assume that the ring depth is a power of two, so the index wraps by overflow. The stimulus sends every event as data words followed by exactly one end-of-event word. It uses status words that are nonzero and have bit 31 clear, so the status written can tell a completed event from a pending one and shows whether the overrun bit is set. The stimulus changes inputs only at the falling edge. It keeps the free FIFO within its depth, apart from one deliberate push while full.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
    } page_desc_t;

    typedef enum logic [2:0] {
        S_FETCH, S_MOVE, S_PLEN, S_PSTAT, S_DRAIN, S_LEN, S_STAT
    } eng_state_e;
endpackage

// File: rtl/pdma_desc_fifo.sv
module pdma_desc_fifo
    import pdma_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  page_desc_t din,
    input  logic       pop,
    output page_desc_t dout,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    page_desc_t         mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   cnt;
    logic               do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt == CNT_W'(DEPTH)) || $past(pop));
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int                RING_DEPTH = 8,
    parameter logic [ADDR_W-1:0] RING_BASE  = 32'h8000_0000,
    parameter int                OVR_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  page_desc_t        desc,
    input  logic              desc_empty,
    output logic              desc_pop,
    input  logic              stop_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eoe,
    output logic              in_ready,
    output logic              mw_valid,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic              done,
    output logic              stopped
);
    localparam int                IDX_W    = $clog2(RING_DEPTH);
    localparam int                WORD_SH  = 2;
    localparam int                ENTRY_SH = 3;
    localparam logic [DATA_W-1:0] OVR_MASK = DATA_W'(1) << OVR_BIT;

    eng_state_e        state, state_nx;
    logic [ADDR_W-1:0] page_q;
    logic [SIZE_W-1:0] size_q, cnt_q;
    logic [DATA_W-1:0] stat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ovr_q, stopped_q;
    logic              accept, room;
    logic [ADDR_W-1:0] ring_len_addr;

    assign accept        = in_valid && in_ready;
    assign room          = (cnt_q < size_q);
    assign ring_len_addr = RING_BASE + (ADDR_W'(idx_q) << ENTRY_SH);
    assign stopped       = stopped_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH: if (desc_pop) state_nx = S_MOVE;
            S_MOVE: begin
                if (accept && in_eoe)     state_nx = S_LEN;
                else if (accept && !room) state_nx = S_PLEN;
            end
            S_PLEN:  state_nx = S_PSTAT;
            S_PSTAT: state_nx = S_DRAIN;
            S_DRAIN: if (accept && in_eoe) state_nx = S_LEN;
            S_LEN:   state_nx = S_STAT;
            S_STAT:  state_nx = S_FETCH;
            default: state_nx = S_FETCH;
        endcase
    end

    always_comb begin
        desc_pop = 1'b0;
        in_ready = 1'b0;
        mw_valid = 1'b0;
        mw_addr  = '0;
        mw_data  = '0;
        done     = 1'b0;
        unique case (state)
            S_FETCH: desc_pop = !desc_empty && !stopped_q;
            S_MOVE: begin
                in_ready = 1'b1;
                mw_valid = in_valid && !in_eoe && room;
                mw_addr  = page_q + (ADDR_W'(cnt_q) << WORD_SH);
                mw_data  = in_data;
            end
            S_PLEN, S_LEN: begin
                mw_valid = 1'b1;
                mw_addr  = ring_len_addr;
                mw_data  = DATA_W'(cnt_q);
            end
            S_PSTAT: begin
                mw_valid = 1'b1;
                mw_addr  = ring_len_addr + ADDR_W'(4);
                mw_data  = '0;
            end
            S_DRAIN: in_ready = 1'b1;
            S_STAT: begin
                mw_valid = 1'b1;
                mw_addr  = ring_len_addr + ADDR_W'(4);
                mw_data  = stat_q;
                done     = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            size_q    <= '0;
            cnt_q     <= '0;
            stat_q    <= '0;
            idx_q     <= '0;
            ovr_q     <= 1'b0;
            stopped_q <= 1'b0;
        end else begin
            if (desc_pop) begin
                page_q <= desc.addr;
                size_q <= desc.size;
                cnt_q  <= '0;
                ovr_q  <= 1'b0;
            end
            if (state == S_MOVE && accept) begin
                if (in_eoe)    stat_q <= in_data;
                else if (room) cnt_q  <= cnt_q + 1'b1;
                else           ovr_q  <= 1'b1;
            end
            if (state == S_DRAIN && accept && in_eoe) stat_q <= in_data | OVR_MASK;
            if (state == S_STAT) begin
                idx_q <= idx_q + 1'b1;
                if (ovr_q && stop_en) stopped_q <= 1'b1;
            end
        end
    end

    // R5
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= size_q);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R8
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_q |=> stopped_q);

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_q |-> !desc_pop);

    // R6
    done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mw_valid && !in_ready);
endmodule

// File: rtl/page_dma_rx.sv
module page_dma_rx
    import pdma_pkg::*;
#(
    parameter int                FREE_DEPTH = 128,
    parameter int                RING_DEPTH = 8,
    parameter logic [ADDR_W-1:0] RING_BASE  = 32'h8000_0000,
    parameter int                OVR_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_push,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [SIZE_W-1:0] desc_size,
    output logic              free_full,
    input  logic              stop_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eoe,
    output logic              in_ready,
    output logic              mw_valid,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic              done,
    output logic              stopped
);
    page_desc_t push_desc, head_desc;
    logic       fifo_empty, fifo_pop;

    assign push_desc = '{addr: desc_addr, size: desc_size};

    pdma_desc_fifo #(.DEPTH(FREE_DEPTH)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (desc_push),
        .din   (push_desc),
        .pop   (fifo_pop),
        .dout  (head_desc),
        .empty (fifo_empty),
        .full  (free_full)
    );

    pdma_engine #(
        .RING_DEPTH (RING_DEPTH),
        .RING_BASE  (RING_BASE),
        .OVR_BIT    (OVR_BIT)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc       (head_desc),
        .desc_empty (fifo_empty),
        .desc_pop   (fifo_pop),
        .stop_en    (stop_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_eoe     (in_eoe),
        .in_ready   (in_ready),
        .mw_valid   (mw_valid),
        .mw_addr    (mw_addr),
        .mw_data    (mw_data),
        .done       (done),
        .stopped    (stopped)
    );
endmodule

// File: tb/page_dma_rx_tb.sv
`timescale 1ns/1ps
module page_dma_rx_tb;
    localparam logic [31:0] RBASE = 32'h8000_0000;
    localparam int          RDEP  = 8;

    // {length in words, page size in words, tag}
    localparam logic [47:0] VEC [10] = '{
        {16'd4,  16'd8,  16'h0A01},
        {16'd8,  16'd8,  16'h0A02},
        {16'd10, 16'd6,  16'h0A03},
        {16'd0,  16'd4,  16'h0A04},
        {16'd3,  16'd0,  16'h0A05},
        {16'd1,  16'd1,  16'h0A06},
        {16'd5,  16'd16, 16'h0A07},
        {16'd12, 16'd4,  16'h0A08},
        {16'd2,  16'd2,  16'h0A09},
        {16'd7,  16'd7,  16'h0A0A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_push = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_size = '0;
    logic        free_full;
    logic        stop_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_eoe = 1'b0;
    logic        in_ready, mw_valid, done, stopped;
    logic [31:0] mw_addr, mw_data;

    int n_chk = 0;
    int n_bad = 0;
    int ring_idx = 0;

    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;
    int          done_cnt = 0;

    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    string       exp_req  [64];
    int          exp_n;

    always #2.5 clk = ~clk;

    page_dma_rx u_dut (
        .clk(clk), .rst_n(rst_n), .desc_push(desc_push), .desc_addr(desc_addr),
        .desc_size(desc_size), .free_full(free_full), .stop_en(stop_en),
        .in_valid(in_valid), .in_data(in_data), .in_eoe(in_eoe), .in_ready(in_ready),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
        .done(done), .stopped(stopped)
    );

    always begin
        @(negedge clk);
        #2;
        if (rst_n && mw_valid && log_n < 256) begin
            log_addr[log_n] = mw_addr;
            log_data[log_n] = mw_data;
            log_n = log_n + 1;
        end
        if (rst_n && done) done_cnt = done_cnt + 1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_desc(input logic [31:0] a, input logic [15:0] s);
        desc_push = 1'b1; desc_addr = a; desc_size = s;
        @(negedge clk);
        desc_push = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input logic e);
        in_valid = 1'b1; in_data = d; in_eoe = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_eoe = 1'b0;
    endtask

    task automatic build_exp(input logic [31:0] a, input int len, input int sz, input logic [31:0] eoe);
        int kept;
        logic [31:0] ra;
        kept = (len < sz) ? len : sz;
        ra = RBASE + 32'(ring_idx * 8);
        exp_n = 0;
        for (int i = 0; i < kept; i++) begin
            exp_addr[exp_n] = a + 32'(4 * i);
            exp_data[exp_n] = {eoe[15:0], 16'(i)};
            exp_req[exp_n]  = "R3 page data";
            exp_n++;
        end
        if (len > sz) begin
            exp_addr[exp_n] = ra;      exp_data[exp_n] = 32'(sz); exp_req[exp_n] = "R5 partial length"; exp_n++;
            exp_addr[exp_n] = ra + 4;  exp_data[exp_n] = 32'h0;   exp_req[exp_n] = "R5 partial status"; exp_n++;
        end
        exp_addr[exp_n] = ra;     exp_data[exp_n] = 32'(kept); exp_req[exp_n] = "R4 final length"; exp_n++;
        exp_addr[exp_n] = ra + 4;
        exp_data[exp_n] = (len > sz) ? (eoe | 32'h8000_0000) : eoe;
        exp_req[exp_n]  = (len > sz) ? "R5 overrun status" : "R4 final status";
        exp_n++;
        ring_idx = (ring_idx + 1) % RDEP;
    endtask

    // sends one event on an already queued descriptor and checks all writes
    task automatic run_event(input logic [31:0] a, input int len, input int sz, input logic [15:0] tag);
        logic [31:0] eoe;
        int d0;
        eoe = {16'h5A00, tag};
        log_n = 0;
        d0 = done_cnt;
        build_exp(a, len, sz, eoe);
        for (int i = 0; i < len; i++) send({tag, 16'(i)}, 1'b0);
        send(eoe, 1'b1);
        chk("R9 in_ready low after end-of-event", 32'(in_ready), 32'd0);
        repeat (4) @(negedge clk);
        chk("R6 one done pulse", 32'(done_cnt - d0), 32'd1);
        chk("R4 write count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            chk({exp_req[i], " addr"}, log_addr[i], exp_addr[i]);
            chk({exp_req[i], " data"}, log_data[i], exp_data[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", 32'(in_ready), 32'd0);
        chk("R1 mw_valid", 32'(mw_valid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 stopped", 32'(stopped), 32'd0);
        chk("R1 free_full", 32'(free_full), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 wait without a page
        in_valid = 1'b1; in_data = 32'hDEAD_0000;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R7 in_ready without descriptor", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        chk("R7 no write without descriptor", 32'(log_n), 32'd0);
        push_desc(32'h1000_0000, 16'd4);
        run_event(32'h1000_0000, 2, 4, 16'h0B00);

        // R3 R4 R5 R6 table of events, stop_en low (R8)
        for (int v = 0; v < 10; v++) begin
            logic [31:0] pa;
            pa = 32'h1000_0000 + 32'((v + 1) * 32'h1000);
            push_desc(pa, VEC[v][31:16]);
            run_event(pa, int'(VEC[v][47:32]), int'(VEC[v][31:16]), VEC[v][15:0]);
            chk("R8 no stop with stop_en low", 32'(stopped), 32'd0);
        end

        // R3 descriptor order: two queued before data
        push_desc(32'h3000_0000, 16'd2);
        push_desc(32'h3100_0000, 16'd2);
        run_event(32'h3000_0000, 1, 2, 16'h0C01);
        run_event(32'h3100_0000, 2, 2, 16'h0C02);

        // R2 free FIFO fill: engine holds one, FIFO holds the rest
        for (int i = 0; i < 129; i++) begin
            push_desc(32'h2000_0000 + 32'(i * 32'h100), 16'd2);
            if (i == 127) chk("R2 not full at 127 held", 32'(free_full), 32'd0);
        end
        chk("R2 full at 128 held", 32'(free_full), 32'd1);
        push_desc(32'h2FFF_0000, 16'd2);
        chk("R2 push while full dropped", 32'(free_full), 32'd1);

        // R8 stop on overrun
        stop_en = 1'b1;
        run_event(32'h2000_0000, 4, 2, 16'h0D01);
        chk("R8 stopped after overrun", 32'(stopped), 32'd1);
        log_n = 0;
        in_valid = 1'b1; in_data = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R8 in_ready held low when stopped", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        chk("R8 no write when stopped", 32'(log_n), 32'd0);
        chk("R8 stopped holds", 32'(stopped), 32'd1);

        // R1 reset clears stop, FIFO and index
        rst_n = 1'b0;
        stop_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 stopped cleared", 32'(stopped), 32'd0);
        chk("R1 free FIFO cleared", 32'(free_full), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 FIFO empty after reset", 32'(in_ready), 32'd0);
        ring_idx = 0;
        push_desc(32'h4000_0000, 16'd4);
        run_event(32'h4000_0000, 3, 4, 16'h0E01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule